// File: doc/BRIEF.md
# PoE Powered-Device Signature Detection Sequencer

This block runs the discovery step that a power-sourcing port performs before it applies power. It steps a probe select line through two probe levels. At each level it waits out a settling period, then averages a fixed number of digitized port-voltage and probe-current samples. The averaging window spans the mains-rejecting integration time, which is 100 ms at the block's sample rate. From the two averages it forms the slope resistance dV/dI, which is the voltage change over the current change. It then reports one verdict code together with a single-cycle done pulse.

Resistance limits are checked by cross-multiplying against scaled constants, so no divider is needed. Besides a valid signature, the verdict can name a port that is open, has too low or too high a resistance, has too much capacitance, or is driven by an external positive or negative supply. Capacitance is judged from how far the high-level voltage still drifts within its window. A large-capacitance enable input relaxes that drift limit.

A start pulse launches a cycle at once. It also restarts a cycle or backoff that is already under way. In midspan mode a failed verdict is followed by a fixed backoff, after which the block retries on its own. A valid verdict ends the retries. States are `ST_IDLE`, `ST_SETTLE_LO`, `ST_INTEG_LO`, `ST_SETTLE_HI`, `ST_INTEG_HI`, `ST_JUDGE` and `ST_BACKOFF`. The transitions are:

- IDLE→SETTLE_LO on start.
- SETTLE_LO→INTEG_LO when the settle timer expires.
- INTEG_LO→SETTLE_HI when the window is full.
- SETTLE_HI→INTEG_HI when the settle timer expires.
- INTEG_HI→JUDGE when the window is full.
- JUDGE→BACKOFF on a failed verdict in midspan mode.
- JUDGE→IDLE otherwise.
- BACKOFF→SETTLE_LO when the backoff timer expires.
- Any state→SETTLE_LO on start.

Top module: `sig_detect_seq`

## Requirements
- R1: After reset, probe_sel is 2'b00 (idle), done is 0 and verdict is 0.
- R2: On each cycle, probe_sel goes 2'b01 (low level), then 2'b10 (high level), then done is high for exactly one cycle with the verdict. probe_sel is 2'b00 in the done cycle and stays idle afterwards unless a retry or start follows.
- R3: Samples that arrive during the first SETTLE_CYC cycles after a level change are discarded. Each level averages exactly the next 2^LOG_NS valid samples, using an arithmetic shift that rounds toward minus infinity.
- R4: With voltage in 10 mV steps and current in 1 µA steps, the verdict is valid (code 1) when 190·dI ≤ 100·dV ≤ 265·dI, with both bounds inclusive. This is 19 kΩ to 26.5 kΩ. dV and dI are the high-level average minus the low-level average.
- R5: A resistance below the valid band gives low resistance (code 3), including the 15–19 kΩ gray zone. A resistance above it gives high resistance (code 4), including the 26.5–33 kΩ gray zone.
- R6: dI below I_OPEN_MIN (20) gives open circuit (code 2).
- R7: Either level average below 0 gives negative supply (code 7). Either average above V_PROBE_MAX (1100) gives positive supply (code 6). Codes are tested in the order 7, 6, 2, 5, 3, 4, and the first match wins.
- R8: High capacitance (code 5) is reported when the drift |second-half sum − first-half sum| of the high-level voltage samples exceeds CAP_LIM. When large_cap_en is 1, the limit is CAP_LIM_BIG instead.
- R9: With midspan at 0, the block stays idle after any verdict until the next start.
- R10: With midspan at 1, a failed verdict is followed by BACKOFF_CYC idle cycles. probe_sel then returns to 2'b01 without a start.
- R11: A valid verdict stops all retries, even in midspan mode.
- R12: A start pulse in any state, including the done cycle and backoff, puts probe_sel at 2'b01 on the next cycle. Accumulation restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin or restart detection |
| midspan | input | 1 | Retry after failure with backoff |
| large_cap_en | input | 1 | Relaxed capacitance drift limit |
| smp_vld | input | 1 | Sample strobe |
| smp_volt | input | V_W | Signed port voltage sample, 10 mV/LSB |
| smp_curr | input | I_W | Signed probe current sample, 1 µA/LSB |
| probe_sel | output | 2 | 00 idle, 01 low level, 10 high level |
| done | output | 1 | One-cycle verdict strobe |
| verdict | output | 3 | Verdict code, 0 when done is low |

## Verification
A start pulse can land in the same cycle as the done pulse of a failed midspan cycle, so the retry decision and the restart meet on one clock edge. The bench raises start exactly in the cycle where done is seen. It expects the failed verdict to be reported in that cycle, probe_sel to show the low level on the next cycle rather than entering backoff, and a second verdict to follow from freshly accumulated samples. A restart during high-level integration is also checked. There the interrupted cycle must deliver no verdict at all.

// File: rtl/sd_pkg.sv
package sd_pkg;

    typedef enum logic [1:0] {
        PROBE_IDLE = 2'b00,
        PROBE_LO   = 2'b01,
        PROBE_HI   = 2'b10
    } probe_e;

    typedef enum logic [2:0] {
        VD_NONE     = 3'd0,
        VD_VALID    = 3'd1,
        VD_OPEN     = 3'd2,
        VD_LOW_R    = 3'd3,
        VD_HIGH_R   = 3'd4,
        VD_HIGH_CAP = 3'd5,
        VD_POS_DC   = 3'd6,
        VD_NEG_DC   = 3'd7
    } verdict_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE_LO,
        ST_INTEG_LO,
        ST_SETTLE_HI,
        ST_INTEG_HI,
        ST_JUDGE,
        ST_BACKOFF
    } state_e;

endpackage

// File: rtl/sd_timer.sv
module sd_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sd_accum.sv
module sd_accum #(
    parameter int V_W    = 12,
    parameter int I_W    = 12,
    parameter int LOG_NS = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         en,
    input  logic                         vld,
    input  logic signed [V_W-1:0]        volt,
    input  logic signed [I_W-1:0]        curr,
    output logic signed [V_W+LOG_NS-1:0] sum_v,
    output logic signed [I_W+LOG_NS-1:0] sum_i,
    output logic signed [V_W+LOG_NS-1:0] sum_va,
    output logic                         full
);
    localparam int SV_W = V_W + LOG_NS;
    localparam int SI_W = I_W + LOG_NS;

    logic [LOG_NS-1:0] cnt;
    logic              take;

    // a sample is only taken while integrating and before the window is full
    assign take = en && vld && !full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_v  <= '0;
            sum_i  <= '0;
            sum_va <= '0;
            cnt    <= '0;
            full   <= 1'b0;
        end else if (clr) begin
            sum_v  <= '0;
            sum_i  <= '0;
            sum_va <= '0;
            cnt    <= '0;
            full   <= 1'b0;
        end else if (take) begin
            sum_v <= sum_v + SV_W'(volt);
            sum_i <= sum_i + SI_W'(curr);
            if (!cnt[LOG_NS-1]) begin
                sum_va <= sum_va + SV_W'(volt);
            end
            cnt <= cnt + 1'b1;
            if (cnt == {LOG_NS{1'b1}}) begin
                full <= 1'b1;
            end
        end
    end

    AST_ACC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr) |=> ($stable(sum_v) && $stable(sum_i))); // R3
    AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!full && sum_v == '0)); // R12
endmodule

// File: rtl/sd_classify.sv
module sd_classify
    import sd_pkg::*;
#(
    parameter int V_W         = 12,
    parameter int I_W         = 12,
    parameter int D_W         = 20,
    parameter int R_UNIT      = 100,
    parameter int R_ACC_LO    = 190,
    parameter int R_ACC_HI    = 265,
    parameter int I_OPEN_MIN  = 20,
    parameter int V_PROBE_MAX = 1100,
    parameter int CAP_LIM     = 2048,
    parameter int CAP_LIM_BIG = 32768
) (
    input  logic signed [V_W-1:0] v_lo,
    input  logic signed [I_W-1:0] i_lo,
    input  logic signed [V_W-1:0] v_hi,
    input  logic signed [I_W-1:0] i_hi,
    input  logic [D_W-1:0]        drift,
    input  logic                  large_cap_en,
    output verdict_e              verdict
);
    localparam int P_W = V_W + I_W + 20;
    localparam logic signed [V_W-1:0] VMAX    = V_W'(V_PROBE_MAX);
    localparam logic signed [P_W-1:0] IOPEN   = P_W'(I_OPEN_MIN);
    localparam logic [D_W-1:0]        CAP_N   = D_W'(CAP_LIM);
    localparam logic [D_W-1:0]        CAP_B   = D_W'(CAP_LIM_BIG);

    logic signed [V_W:0]   dv;
    logic signed [I_W:0]   di;
    logic signed [P_W-1:0] dv_scaled;
    logic signed [P_W-1:0] di_lo_lim;
    logic signed [P_W-1:0] di_hi_lim;
    logic                  neg_dc, pos_dc, open_c, cap_big, r_low, r_high;

    always_comb begin
        dv        = (V_W+1)'(v_hi) - (V_W+1)'(v_lo);
        di        = (I_W+1)'(i_hi) - (I_W+1)'(i_lo);
        dv_scaled = P_W'(dv) * P_W'(R_UNIT);
        di_lo_lim = P_W'(di) * P_W'(R_ACC_LO);
        di_hi_lim = P_W'(di) * P_W'(R_ACC_HI);

        neg_dc  = v_lo[V_W-1] || v_hi[V_W-1];
        pos_dc  = (v_lo > VMAX) || (v_hi > VMAX);
        open_c  = P_W'(di) < IOPEN;
        cap_big = drift > (large_cap_en ? CAP_B : CAP_N);
        r_low   = dv_scaled < di_lo_lim;
        r_high  = dv_scaled > di_hi_lim;

        if (neg_dc)       verdict = VD_NEG_DC;
        else if (pos_dc)  verdict = VD_POS_DC;
        else if (open_c)  verdict = VD_OPEN;
        else if (cap_big) verdict = VD_HIGH_CAP;
        else if (r_low)   verdict = VD_LOW_R;
        else if (r_high)  verdict = VD_HIGH_R;
        else              verdict = VD_VALID;
    end
endmodule

// File: rtl/sig_detect_seq.sv
module sig_detect_seq
    import sd_pkg::*;
#(
    parameter int V_W         = 12,
    parameter int I_W         = 12,
    parameter int LOG_NS      = 7,
    parameter int SETTLE_CYC  = 10000,
    parameter int BACKOFF_CYC = 22000000,
    parameter int R_UNIT      = 100,
    parameter int R_ACC_LO    = 190,
    parameter int R_ACC_HI    = 265,
    parameter int I_OPEN_MIN  = 20,
    parameter int V_PROBE_MAX = 1100,
    parameter int CAP_LIM     = 2048,
    parameter int CAP_LIM_BIG = 32768
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  midspan,
    input  logic                  large_cap_en,
    input  logic                  smp_vld,
    input  logic signed [V_W-1:0] smp_volt,
    input  logic signed [I_W-1:0] smp_curr,
    output logic [1:0]            probe_sel,
    output logic                  done,
    output logic [2:0]            verdict
);
    localparam int SV_W = V_W + LOG_NS;
    localparam int SI_W = I_W + LOG_NS;
    localparam int D_W  = SV_W + 1;
    localparam int TMAX = (BACKOFF_CYC > SETTLE_CYC) ? BACKOFF_CYC : SETTLE_CYC;
    localparam int TW   = $clog2(TMAX) + 1;
    localparam logic [TW-1:0] SETTLE_LOAD  = TW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] BACKOFF_LOAD = TW'(BACKOFF_CYC - 1);

    state_e state, state_n;

    logic                   tmr_load, tmr_exp;
    logic [TW-1:0]          tmr_val;
    logic                   acc_en, acc_full;
    logic signed [SV_W-1:0] sum_v, sum_va;
    logic signed [SI_W-1:0] sum_i;
    logic signed [SV_W:0]   half_gap;
    logic [D_W-1:0]         drift_now;

    logic signed [V_W-1:0]  v_lo_q, v_hi_q;
    logic signed [I_W-1:0]  i_lo_q, i_hi_q;
    logic [D_W-1:0]         drift_q;
    verdict_e               verdict_w;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:      state_n = ST_IDLE;
            ST_SETTLE_LO: if (tmr_exp)  state_n = ST_INTEG_LO;
            ST_INTEG_LO:  if (acc_full) state_n = ST_SETTLE_HI;
            ST_SETTLE_HI: if (tmr_exp)  state_n = ST_INTEG_HI;
            ST_INTEG_HI:  if (acc_full) state_n = ST_JUDGE;
            ST_JUDGE:     state_n = (verdict_w != VD_VALID && midspan) ? ST_BACKOFF : ST_IDLE;
            ST_BACKOFF:   if (tmr_exp)  state_n = ST_SETTLE_LO;
            default:      state_n = ST_IDLE;
        endcase
        // a start always wins and begins a fresh cycle
        if (start) state_n = ST_SETTLE_LO;
    end

    // ---------------- shared settle / backoff timer ----------------
    assign tmr_load = start || (state_n != state);
    assign tmr_val  = (state_n == ST_BACKOFF) ? BACKOFF_LOAD : SETTLE_LOAD;

    sd_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    // ---------------- integrator ----------------
    assign acc_en = (state == ST_INTEG_LO) || (state == ST_INTEG_HI);

    sd_accum #(.V_W(V_W), .I_W(I_W), .LOG_NS(LOG_NS)) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!acc_en),
        .en     (acc_en),
        .vld    (smp_vld),
        .volt   (smp_volt),
        .curr   (smp_curr),
        .sum_v  (sum_v),
        .sum_i  (sum_i),
        .sum_va (sum_va),
        .full   (acc_full)
    );

    // second-half sum minus first-half sum = total - 2 * first half
    always_comb begin
        half_gap  = (SV_W+1)'(sum_v) - ((SV_W+1)'(sum_va) <<< 1);
        drift_now = half_gap[SV_W] ? D_W'(-half_gap) : D_W'(half_gap);
    end

    // ---------------- level averages ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_lo_q  <= '0;
            i_lo_q  <= '0;
            v_hi_q  <= '0;
            i_hi_q  <= '0;
            drift_q <= '0;
        end else begin
            if (state == ST_INTEG_LO && acc_full) begin
                v_lo_q <= V_W'(sum_v >>> LOG_NS);
                i_lo_q <= I_W'(sum_i >>> LOG_NS);
            end
            if (state == ST_INTEG_HI && acc_full) begin
                v_hi_q  <= V_W'(sum_v >>> LOG_NS);
                i_hi_q  <= I_W'(sum_i >>> LOG_NS);
                drift_q <= drift_now;
            end
        end
    end

    sd_classify #(
        .V_W(V_W), .I_W(I_W), .D_W(D_W),
        .R_UNIT(R_UNIT), .R_ACC_LO(R_ACC_LO), .R_ACC_HI(R_ACC_HI),
        .I_OPEN_MIN(I_OPEN_MIN), .V_PROBE_MAX(V_PROBE_MAX),
        .CAP_LIM(CAP_LIM), .CAP_LIM_BIG(CAP_LIM_BIG)
    ) u_classify (
        .v_lo         (v_lo_q),
        .i_lo         (i_lo_q),
        .v_hi         (v_hi_q),
        .i_hi         (i_hi_q),
        .drift        (drift_q),
        .large_cap_en (large_cap_en),
        .verdict      (verdict_w)
    );

    // ---------------- outputs ----------------
    always_comb begin
        probe_sel = PROBE_IDLE;
        done      = 1'b0;
        verdict   = VD_NONE;
        unique case (state)
            ST_SETTLE_LO, ST_INTEG_LO: probe_sel = PROBE_LO;
            ST_SETTLE_HI, ST_INTEG_HI: probe_sel = PROBE_HI;
            ST_JUDGE: begin
                done    = 1'b1;
                verdict = verdict_w;
            end
            default: probe_sel = PROBE_IDLE;
        endcase
    end

    // ---------------- assertions ----------------
    AST_START_LOW_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (probe_sel == PROBE_LO)); // R12
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_HIGH_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_sel == PROBE_HI && $past(probe_sel) != PROBE_HI) |-> ($past(probe_sel) == PROBE_LO)); // R2
    AST_VALID_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && verdict == VD_VALID && !start) |=> (state == ST_IDLE)); // R11
    AST_FAIL_BACKS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (done && verdict != VD_VALID && midspan && !start) |=> (state == ST_BACKOFF)); // R10
    AST_PLAIN_FAIL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !midspan && !start) |=> (probe_sel == PROBE_IDLE && !done)); // R9
    AST_CODE_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (verdict != VD_NONE)); // R4
endmodule

// File: tb/sig_detect_seq_test.sv
module sig_detect_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 12;
    localparam int BACKOFF    = 150;
    localparam int LOG_NS     = 3;
    localparam int N          = 1 << LOG_NS;
    localparam int SMP_EVERY  = 3;
    localparam int CAP_N      = 64;
    localparam int CAP_B      = 512;

    typedef struct {
        int    code;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic midspan = 1'b0;
    logic large_en = 1'b0;
    logic smp_vld = 1'b0;
    logic signed [11:0] smp_volt = '0;
    logic signed [11:0] smp_curr = '0;
    logic [1:0] probe_sel;
    logic done;
    logic [2:0] verdict;

    int n_chk = 0;
    int n_fail = 0;
    int n_seen = 0;
    exp_t exp_q[$];

    int sv1, si1, sv2, si2, sramp;

    always #(CLK_PERIOD/2) clk = ~clk;

    sig_detect_seq #(
        .V_W(12), .I_W(12), .LOG_NS(LOG_NS),
        .SETTLE_CYC(SETTLE), .BACKOFF_CYC(BACKOFF),
        .CAP_LIM(CAP_N), .CAP_LIM_BIG(CAP_B)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .midspan(midspan),
        .large_cap_en(large_en), .smp_vld(smp_vld), .smp_volt(smp_volt),
        .smp_curr(smp_curr), .probe_sel(probe_sel), .done(done), .verdict(verdict)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected verdict from the requirement rules (R3..R8)
    function automatic int ref_verdict(input int v1, input int i1, input int v2,
                                       input int i2, input int r, input bit big);
        int s2 = 0;
        int sa = 0;
        int a2, dv, di, drift;
        for (int j = 0; j < N; j++) begin
            s2 += v2 + r * j;
            if (j < N / 2) sa += v2 + r * j;
        end
        a2    = s2 >>> LOG_NS;
        drift = s2 - 2 * sa;
        if (drift < 0) drift = -drift;
        dv = a2 - v1;
        di = i2 - i1;
        if (v1 < 0 || a2 < 0)                    return 7;
        if (v1 > 1100 || a2 > 1100)              return 6;
        if (di < 20)                             return 2;
        if (drift > (big ? CAP_B : CAP_N))       return 5;
        if (100 * dv < 190 * di)                 return 3;
        if (100 * dv > 265 * di)                 return 4;
        return 1;
    endfunction

    // port model: garbage while settling (R3), level values afterwards
    int k_lvl = 0;
    int g_idx = 0;
    int phase = 0;
    logic [1:0] prev_sel = 2'b00;
    always @(negedge clk) begin
        if (probe_sel != prev_sel) begin
            k_lvl = 0;
            g_idx = 0;
        end else begin
            k_lvl++;
        end
        prev_sel = probe_sel;
        phase = (phase + 1) % SMP_EVERY;
        smp_vld <= 1'b0;
        if (probe_sel != 2'b00 && phase == 0) begin
            smp_vld <= 1'b1;
            if (k_lvl < SETTLE) begin
                smp_volt <= 12'sd1500;
                smp_curr <= 12'sd1500;
            end else if (probe_sel == 2'b01) begin
                smp_volt <= 12'(sv1);
                smp_curr <= 12'(si1);
            end else begin
                smp_volt <= 12'(sv2 + sramp * g_idx);
                smp_curr <= 12'(si2);
                g_idx++;
            end
        end
    end

    // monitor: compare each verdict against the scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            n_seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected done", int'(verdict), 0);
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                check(int'(verdict) == it.code, it.tag, int'(verdict), it.code);
            end
        end
    end

    task automatic set_scen(input int v1, input int i1, input int v2, input int i2, input int r);
        sv1 = v1; si1 = i1; sv2 = v2; si2 = i2; sramp = r;
    endtask

    task automatic push_exp(input string tag);
        exp_t it;
        it.code = ref_verdict(sv1, si1, sv2, si2, sramp, large_en);
        it.tag  = tag;
        exp_q.push_back(it);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(probe_sel == 2'b01, "R2 low level after start", int'(probe_sel), 1);
    endtask

    task automatic wait_done();
        int base = n_seen;
        while (n_seen == base) @(negedge clk);
    endtask

    task automatic run_case(input int v1, input int i1, input int v2, input int i2,
                            input int r, input bit big, input string tag);
        set_scen(v1, i1, v2, i2, r);
        large_en = big;
        midspan  = 1'b0;
        push_exp(tag);
        pulse_start();
        wait_done();
        @(negedge clk);
        check(probe_sel == 2'b00, "R9 idle after verdict", int'(probe_sel), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(probe_sel == 2'b00, "R1 probe idle in reset", int'(probe_sel), 0);
        check(done == 1'b0, "R1 done low in reset", int'(done), 0);
        check(verdict == 3'd0, "R1 verdict zero in reset", int'(verdict), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        run_case(400, 160, 900, 360, 0, 1'b0, "R3 R4 valid 25k");
        run_case(400, 400, 900, 900, 0, 1'b0, "R5 low 10k");
        run_case(400, 235, 900, 529, 0, 1'b0, "R5 gray 17k rejected");
        run_case(400, 100, 900, 225, 0, 1'b0, "R5 high 40k");
        run_case(400, 100, 590, 200, 0, 1'b0, "R4 lower edge inclusive");
        run_case(400, 100, 591, 201, 0, 1'b0, "R5 just below band");
        run_case(400, 100, 665, 200, 0, 1'b0, "R4 upper edge inclusive");
        run_case(400, 100, 666, 200, 0, 1'b0, "R5 just above band");
        run_case(400, 2, 900, 5, 0, 1'b0, "R6 open port");
        run_case(400, 100, 450, 120, 0, 1'b0, "R6 dI at limit");
        run_case(400, 100, 450, 119, 0, 1'b0, "R6 dI below limit");
        run_case(1200, 10, 1300, 15, 0, 1'b0, "R7 positive supply");
        run_case(-300, -5, -200, -3, 0, 1'b0, "R7 negative supply priority");
        run_case(400, 160, 900, 360, 6, 1'b0, "R8 drift over normal limit");
        run_case(400, 160, 900, 360, 6, 1'b1, "R8 drift within large limit");
        run_case(400, 160, 900, 360, 40, 1'b1, "R8 drift over large limit");

        // R9: no retry without midspan after a failure
        begin
            bit quiet = 1'b1;
            for (int c = 0; c < 2 * BACKOFF; c++) begin
                @(negedge clk);
                if (probe_sel != 2'b00 || done) quiet = 1'b0;
            end
            check(quiet, "R9 stays idle without midspan", int'(quiet), 1);
        end

        // R10/R11: midspan failure, backoff, then a valid retry that halts
        set_scen(400, 400, 900, 900, 0);
        large_en = 1'b0;
        midspan  = 1'b1;
        push_exp("R10 midspan first failure");
        pulse_start();
        do @(negedge clk); while (!done);
        set_scen(400, 160, 900, 360, 0);
        push_exp("R10 retry after backoff");
        begin
            int n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (probe_sel != 2'b01 && n < 1000);
            check(n == BACKOFF + 1, "R10 backoff length", n, BACKOFF + 1);
        end
        wait_done();
        begin
            bit quiet = 1'b1;
            for (int c = 0; c < 2 * BACKOFF; c++) begin
                @(negedge clk);
                if (probe_sel != 2'b00 || done) quiet = 1'b0;
            end
            check(quiet, "R11 no retry after valid", int'(quiet), 1);
        end

        // R12: restart during high-level integration, only the new cycle reports
        midspan = 1'b0;
        set_scen(400, 400, 900, 900, 0);
        pulse_start();
        while (probe_sel != 2'b10) @(negedge clk);
        repeat (SETTLE + 6) @(negedge clk);
        set_scen(400, 160, 900, 360, 0);
        push_exp("R12 restart mid cycle");
        pulse_start();
        wait_done();

        // collision: start in the same cycle as a failed midspan done
        midspan = 1'b1;
        set_scen(400, 100, 900, 225, 0);
        push_exp("R10 collision first verdict");
        pulse_start();
        do @(negedge clk); while (!done);
        start = 1'b1;
        set_scen(400, 160, 900, 360, 0);
        push_exp("R12 collision restart verdict");
        @(negedge clk) start = 1'b0;
        check(probe_sel == 2'b01, "R12 start beats backoff", int'(probe_sel), 1);
        wait_done();

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R2 all verdicts delivered", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule